// File: doc/BRIEF.md
# Block Transfer Byte Packer

This engine sits between a 16-bit word FIFO and a byte-wide card data path. On receive it gathers card bytes in pairs and pushes each pair into the FIFO as one word. On transmit it takes the word at the FIFO head and sends it to the card one byte at a time. Two counters shape every transfer. One counts bytes within the current block, the other counts the blocks still to go.

Software sets a block length and a block count. Each is stored as the written 11-bit field plus one. A data command arms the engine with a direction and flushes the FIFO. After that, one byte can move per clock whenever the card handshake allows it and the FIFO watermark permits. At the end of each block the byte counter reloads. When the last block ends, the block counter reloads, the engine goes idle and a sticky done flag rises.

Top module: `blk_byte_packer`

## Requirements
- R1: A length write with field value F makes `byte_cnt` read F+1 on the next cycle. F is 11 bits, so lengths run from 1 to 2048.
- R2: A count write with field value F makes `blk_cnt` read F+1 on the next cycle. It also reloads `byte_cnt` from the programmed block length.
- R3: A command with `cmd_is_data`=1 raises `fifo_flush` in the same cycle. On the next cycle it sets `active` and latches `cmd_dir` (1 = receive from card, 0 = transmit to card). A command with `cmd_is_data`=0 clears `active`.
- R4: On receive, the first byte of a pair is placed in bits 7:0 and the second in bits 15:8. The word is pushed (`fifo_push`=1, `fifo_wdata`) in the same cycle the second byte is accepted.
- R5: If the accepted byte is the last byte of a block and it would be the first byte of a pair, the word is pushed at once with bits 15:8 equal to zero.
- R6: On transmit, `tx_data` carries bits 7:0 of `fifo_rdata` first and then bits 15:8. `fifo_pop` is raised with the high byte, or with the low byte when that byte ends the block.
- R7: `rx_ready` stays low while `fifo_level` > `af_level`. `tx_valid` stays low while `fifo_empty` is high. No counter moves while the engine is stalled this way.
- R8: Each exchanged byte lowers `byte_cnt` by one. The last byte of a block instead reloads `byte_cnt` from the block length and lowers `blk_cnt` by one.
- R9: The last byte of the last block reloads `blk_cnt` from the programmed count, clears `active` and sets `done`. `done` stays set until `done_clr`.
- R10: While `enable` is low, the lengths, both counters, `active` and `done` are held at zero, and writes and commands are ignored.
- R11: No byte is exchanged while the engine is idle, or in a cycle that carries a command, a length write or a count write.
- R12: A block boundary resets the byte phase. With an odd length, the first byte of every block starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low aborts and clears |
| len_wr | input | 1 | Block length write strobe |
| len_val | input | 11 | Block length field (length minus one) |
| cnt_wr | input | 1 | Block count write strobe |
| cnt_val | input | 11 | Block count field (count minus one) |
| cmd_start | input | 1 | Command issued this cycle |
| cmd_is_data | input | 1 | Command is a data transfer |
| cmd_dir | input | 1 | 1 receive from card, 0 transmit to card |
| done_clr | input | 1 | Clears the done flag |
| af_level | input | 5 | Receive almost-full watermark |
| fifo_level | input | 6 | Current FIFO occupancy in words |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 16 | Word at the FIFO head |
| fifo_push | output | 1 | Push `fifo_wdata` into the FIFO |
| fifo_wdata | output | 16 | Packed receive word |
| fifo_pop | output | 1 | Remove the FIFO head word |
| fifo_flush | output | 1 | Empty the FIFO |
| rx_valid | input | 1 | Card offers a byte |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Engine takes the offered byte |
| tx_valid | output | 1 | Engine offers a byte to the card |
| tx_data | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the offered byte |
| byte_cnt | output | 12 | Live byte counter |
| blk_cnt | output | 12 | Live block counter |
| active | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
The assertions rely on a few things about the inputs. The FIFO level and empty flag must reflect the actual FIFO. Length and count writes must never arrive together with a command. The almost-full level must leave at least one free word when `fifo_level` equals it. The stimulus meets these conditions by keeping the modelled FIFO level at or below the watermark, except during the stall test. It also issues at most one write strobe or command per cycle and changes inputs only on the falling clock edge.

// File: rtl/bbp_pkg.sv
`timescale 1ns/1ps
package bbp_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} xfer_dir_e;
endpackage

// File: rtl/bbp_counters.sv
`timescale 1ns/1ps
module bbp_counters #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             cnt_wr,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             step,
  output logic [LEN_W:0]   byte_cnt,
  output logic [LEN_W:0]   blk_cnt,
  output logic             last_byte,
  output logic             last_blk,
  output logic             cfg_ok
);
  localparam int CNT_W = LEN_W + 1;

  function automatic logic [CNT_W-1:0] fn_field(input logic [LEN_W-1:0] f);
    return {1'b0, f} + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] blk_len, blk_num, len_next;

  assign len_next  = len_wr ? fn_field(len_val) : blk_len;
  assign last_byte = (byte_cnt == CNT_W'(1));
  assign last_blk  = (blk_cnt == CNT_W'(1));
  assign cfg_ok    = (byte_cnt != '0) && (blk_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_len <= '0; blk_num <= '0; byte_cnt <= '0; blk_cnt <= '0;
    end else if (!enable) begin
      blk_len <= '0; blk_num <= '0; byte_cnt <= '0; blk_cnt <= '0;
    end else if (len_wr || cnt_wr) begin
      if (len_wr) begin
        blk_len  <= len_next;
        byte_cnt <= len_next;
      end
      if (cnt_wr) begin
        blk_num  <= fn_field(cnt_val);
        blk_cnt  <= fn_field(cnt_val);
        byte_cnt <= len_next;
      end
    end else if (step) begin
      if (last_byte) begin
        byte_cnt <= blk_len;
        blk_cnt  <= last_blk ? blk_num : blk_cnt - CNT_W'(1);
      end else begin
        byte_cnt <= byte_cnt - CNT_W'(1);
      end
    end
  end

  p_len_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable && len_wr && !cnt_wr |=> byte_cnt == fn_field($past(len_val)));
  p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt_wr && !len_wr |=> blk_cnt == fn_field($past(cnt_val)) && byte_cnt == $past(blk_len));
  p_byte_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step && !len_wr && !cnt_wr && !last_byte |=> byte_cnt == $past(byte_cnt) - CNT_W'(1));
  p_blk_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step && !len_wr && !cnt_wr && last_byte && !last_blk
    |=> blk_cnt == $past(blk_cnt) - CNT_W'(1) && byte_cnt == $past(blk_len));
  p_blk_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step && !len_wr && !cnt_wr && last_byte && last_blk |=> blk_cnt == $past(blk_num));
endmodule

// File: rtl/bbp_lane.sv
`timescale 1ns/1ps
module bbp_lane #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rx_fire,
  input  logic              tx_fire,
  input  logic              last_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [WORD_W-1:0] head_word,
  output logic              phase,
  output logic              word_done,
  output logic [WORD_W-1:0] push_word,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [BYTE_W-1:0] hold;
  logic              fire;

  function automatic logic [WORD_W-1:0] fn_pack(input logic hi, input logic [BYTE_W-1:0] lo_b,
                                                input logic [BYTE_W-1:0] new_b);
    return hi ? {new_b, lo_b} : {{BYTE_W{1'b0}}, new_b};
  endfunction

  assign fire      = rx_fire | tx_fire;
  assign word_done = fire & (phase | last_byte);
  assign push_word = fn_pack(phase, hold, rx_byte);
  assign tx_byte   = phase ? head_word[WORD_W-1:BYTE_W] : head_word[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hold  <= '0;
    end else if (clear) begin
      phase <= 1'b0;
    end else if (fire) begin
      phase <= ~phase & ~last_byte;
      if (rx_fire && !phase) hold <= rx_byte;
    end
  end

  p_phase_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_byte |=> !phase);
  p_pair_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && phase && !clear |=> !phase);
endmodule

// File: rtl/blk_byte_packer.sv
`timescale 1ns/1ps
module blk_byte_packer #(
  parameter int LEN_W      = 11,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 32,
  localparam int WORD_W    = 2 * BYTE_W,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              cnt_wr,
  input  logic [LEN_W-1:0]  cnt_val,
  input  logic              cmd_start,
  input  logic              cmd_is_data,
  input  logic              cmd_dir,
  input  logic              done_clr,
  input  logic [LVL_W-2:0]  af_level,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              fifo_pop,
  output logic              fifo_flush,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic              active,
  output logic              done
);
  import bbp_pkg::*;

  xfer_dir_e dir_q;
  logic cfg_busy, cfg_ok, move_ok, rx_fire, tx_fire, step;
  logic last_byte, last_blk, xfer_end, word_done, phase;

  assign cfg_busy = cmd_start | len_wr | cnt_wr;
  assign move_ok  = enable & active & ~cfg_busy & cfg_ok;
  assign rx_ready = move_ok & (dir_q == DIR_RX) & (fifo_level <= LVL_W'(af_level));
  assign tx_valid = move_ok & (dir_q == DIR_TX) & ~fifo_empty;
  assign rx_fire  = rx_valid & rx_ready;
  assign tx_fire  = tx_valid & tx_ready;
  assign step     = rx_fire | tx_fire;
  assign xfer_end = step & last_byte & last_blk;

  assign fifo_flush = enable & cmd_start & cmd_is_data;
  assign fifo_push  = word_done & rx_fire;
  assign fifo_pop   = word_done & tx_fire;

  bbp_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .len_wr(len_wr), .len_val(len_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .step(step), .byte_cnt(byte_cnt), .blk_cnt(blk_cnt),
    .last_byte(last_byte), .last_blk(last_blk), .cfg_ok(cfg_ok)
  );

  bbp_lane #(.BYTE_W(BYTE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .clear(~enable | cmd_start),
    .rx_fire(rx_fire), .tx_fire(tx_fire), .last_byte(last_byte),
    .rx_byte(rx_data), .head_word(fifo_rdata),
    .phase(phase), .word_done(word_done), .push_word(fifo_wdata), .tx_byte(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir_q  <= DIR_TX;
      done   <= 1'b0;
    end else if (!enable) begin
      active <= 1'b0;
      dir_q  <= DIR_TX;
      done   <= 1'b0;
    end else begin
      if (cmd_start) begin
        active <= cmd_is_data;
        if (cmd_is_data) dir_q <= xfer_dir_e'(cmd_dir);
      end else if (xfer_end) begin
        active <= 1'b0;
      end
      if (xfer_end)      done <= 1'b1;
      else if (done_clr) done <= 1'b0;
    end
  end

  p_flush_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> active);
  p_nodata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cmd_start && !cmd_is_data |=> !active);
  p_push_rx_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> rx_valid && dir_q == DIR_RX);
  p_pop_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> tx_valid && tx_ready);
  p_rx_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level > LVL_W'(af_level)) |-> !rx_ready);
  p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !tx_valid);
  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(active) && !active);
  p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> byte_cnt == '0 && blk_cnt == '0 && !active && !done);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || cfg_busy) |-> !rx_ready && !tx_valid);
endmodule

// File: tb/sim_blk_byte_packer.sv
`timescale 1ns/1ps
module sim_blk_byte_packer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enable, len_wr, cnt_wr, cmd_start, cmd_is_data, cmd_dir, done_clr;
  logic [10:0] len_val, cnt_val;
  logic [4:0] af_level;
  logic [5:0] fifo_level;
  logic fifo_empty, rx_valid, tx_ready;
  logic [15:0] fifo_rdata;
  logic [7:0] rx_data;
  logic fifo_push, fifo_pop, fifo_flush, rx_ready, tx_valid, active, done;
  logic [15:0] fifo_wdata;
  logic [7:0] tx_data;
  logic [11:0] byte_cnt, blk_cnt;

  blk_byte_packer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .len_wr(len_wr), .len_val(len_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .cmd_start(cmd_start), .cmd_is_data(cmd_is_data),
    .cmd_dir(cmd_dir), .done_clr(done_clr), .af_level(af_level), .fifo_level(fifo_level),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .byte_cnt(byte_cnt), .blk_cnt(blk_cnt),
    .active(active), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int gbyte  = 0;
  int gword  = 0;

  // {dir(1=rx), length field, count field}
  localparam logic [22:0] VEC [4] = '{
    {1'b1, 11'd2, 11'd1},
    {1'b1, 11'd3, 11'd0},
    {1'b0, 11'd4, 11'd1},
    {1'b0, 11'd1, 11'd2}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bgen(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  function automatic logic [15:0] wgen(input int n);
    return 16'(16'hA500 + n * 16'h0123);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic program_lc(input int lf, input int cf);
    len_wr = 1; len_val = 11'(lf); tick(); len_wr = 0;
    chk(byte_cnt == 12'(lf + 1), "R1 len load", byte_cnt, lf + 1);
    cnt_wr = 1; cnt_val = 11'(cf); tick(); cnt_wr = 0;
    chk(blk_cnt == 12'(cf + 1), "R2 cnt load", blk_cnt, cf + 1);
    chk(byte_cnt == 12'(lf + 1), "R2 byte reload", byte_cnt, lf + 1);
  endtask

  task automatic start_cmd(input logic data, input logic dir);
    cmd_start = 1; cmd_is_data = data; cmd_dir = dir;
    #1;
    chk(fifo_flush == data, "R3 flush", fifo_flush, data);
    chk(!rx_ready && !tx_valid, "R11 quiet on cmd", {rx_ready, tx_valid}, 0);
    @(negedge clk);
    cmd_start = 0; cmd_is_data = 0;
    chk(active == data, "R3 active", active, data);
  endtask

  task automatic run_vec(input logic dir, input int lf, input int cf);
    int L = lf + 1;
    int C = cf + 1;
    logic [7:0] lo_b;
    logic [15:0] ew;
    program_lc(lf, cf);
    start_cmd(1'b1, dir);
    for (int b = 0; b < C; b++) begin
      for (int k = 0; k < L; k++) begin
        logic wd = (k % 2 == 1) || (k == L - 1);
        if (dir) begin
          rx_valid = 1; rx_data = bgen(gbyte);
          #1;
          chk(rx_ready, "R4 rx ready", rx_ready, 1);
          chk(fifo_push == wd, "R4 push timing", fifo_push, wd);
          if (wd) begin
            ew = (k % 2 == 1) ? {rx_data, lo_b} : {8'h00, rx_data};
            chk(fifo_wdata == ew, (k % 2 == 1) ? "R4 pack" : "R5 odd pack", fifo_wdata, ew);
          end
          lo_b = rx_data;
          gbyte++;
        end else begin
          tx_ready = 1; fifo_empty = 0; fifo_rdata = wgen(gword);
          #1;
          chk(tx_valid, "R6 tx valid", tx_valid, 1);
          ew = {8'h00, (k % 2 == 1) ? fifo_rdata[15:8] : fifo_rdata[7:0]};
          chk(tx_data == ew[7:0], (k == 0) ? "R12 block start low" : "R6 byte order", tx_data, ew[7:0]);
          chk(fifo_pop == wd, "R6 pop timing", fifo_pop, wd);
          if (wd) gword++;
        end
        tick();
        chk(byte_cnt == 12'((k == L - 1) ? L : L - k - 1), "R8 byte count", byte_cnt,
            (k == L - 1) ? L : L - k - 1);
      end
      chk(blk_cnt == 12'((b == C - 1) ? C : C - b - 1), "R8 block count", blk_cnt,
          (b == C - 1) ? C : C - b - 1);
    end
    rx_valid = 0; tx_ready = 0; fifo_empty = 1;
    chk(done && !active, "R9 done set", {done, active}, 2);
    tick();
    chk(done, "R9 done holds", done, 1);
    done_clr = 1; tick(); done_clr = 0;
    chk(!done, "R9 done clear", done, 0);
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 1; len_wr = 0; cnt_wr = 0; len_val = 0; cnt_val = 0;
    cmd_start = 0; cmd_is_data = 0; cmd_dir = 0; done_clr = 0; af_level = 5'd31;
    fifo_level = 0; fifo_empty = 1; fifo_rdata = 0; rx_valid = 0; rx_data = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(byte_cnt == 0 && blk_cnt == 0, "R10 reset counters", {byte_cnt, blk_cnt}, 0);
    chk(!active && !done, "R10 reset flags", {active, done}, 0);
    rx_valid = 1; tx_ready = 1; fifo_empty = 0; #1;
    chk(!rx_ready && !tx_valid, "R11 idle quiet", {rx_ready, tx_valid}, 0);
    rx_valid = 0; tx_ready = 0; fifo_empty = 1;
    @(negedge clk);

    for (int i = 0; i < 4; i++)
      run_vec(VEC[i][22], int'(VEC[i][21:11]), int'(VEC[i][10:0]));

    // R7 receive stall on watermark
    program_lc(3, 0);
    start_cmd(1'b1, 1'b1);
    af_level = 5'd4; fifo_level = 6'd5; rx_valid = 1; rx_data = 8'h5A; #1;
    chk(!rx_ready && !fifo_push, "R7 rx stall", rx_ready, 0);
    tick();
    chk(byte_cnt == 12'd4, "R7 count frozen", byte_cnt, 4);
    fifo_level = 6'd4; #1;
    chk(rx_ready, "R7 rx resume", rx_ready, 1);
    tick();
    chk(byte_cnt == 12'd3, "R7 resumed count", byte_cnt, 3);
    // R11 config write blocks a byte
    len_wr = 1; len_val = 11'd3; #1;
    chk(!rx_ready, "R11 quiet on write", rx_ready, 0);
    tick(); len_wr = 0; rx_valid = 0; fifo_level = 0; af_level = 5'd31;
    // R3 non-data command clears active
    start_cmd(1'b0, 1'b0);
    chk(!active, "R3 nondata idle", active, 0);

    // R7 transmit idle on empty FIFO
    start_cmd(1'b1, 1'b0);
    fifo_empty = 1; tx_ready = 1; #1;
    chk(!tx_valid, "R7 tx empty", tx_valid, 0);
    tick();
    chk(byte_cnt == 12'd4, "R7 tx count frozen", byte_cnt, 4);
    tx_ready = 0;

    // R10 enable low aborts and ignores writes
    enable = 0; tick();
    chk(byte_cnt == 0 && blk_cnt == 0 && !active, "R10 abort", {byte_cnt, blk_cnt, active}, 0);
    len_wr = 1; len_val = 11'd9; tick(); len_wr = 0;
    chk(byte_cnt == 0, "R10 write ignored", byte_cnt, 0);
    cmd_start = 1; cmd_is_data = 1; #1;
    chk(!fifo_flush, "R10 cmd ignored", fifo_flush, 0);
    tick(); cmd_start = 0; cmd_is_data = 0;
    chk(!active, "R10 stays idle", active, 0);
    enable = 1; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule